// File: doc/BRIEF.md
# Tagged Command/Data Transmit Queue

This block sits in front of the shift engine of an SPI master. Software writes either a configuration word or a data word. Both kinds of write enter one ordered FIFO, and each entry carries a tag that marks it as configuration or data. Because of this, a configuration change takes effect at its own place in the stream, between data frames, and not at the moment it was written.

At the head of the queue, a configuration entry is moved into the active configuration register. A data entry is offered to the shift engine as a frame request, which carries the active configuration. A configuration word can also start a frame that has no data payload. If a configuration entry reaches the head while the engine is mid-frame, the block signals the engine to end that frame, unless the new word asks to continue the stream and the engine is at a frame boundary. When chip select negates, the no-data bit is removed from the active word. A readback port always shows the active word.

Top module: `spi_txq_top`

## Requirements
- R1: Configuration and data writes are delivered to the head strictly in write order. Data frames reach the engine in the order they were written.
- R2: A configuration entry is applied to the active register only when it reaches the head. Every later frame request carries that word on `frm_cfg` until another configuration entry is applied.
- R3: The active configuration does not change while no configuration entry is being applied and chip select is not negating.
- R4: After reset the active configuration is 0x0000001F (frame-size field bits [4:0] = 31, meaning 32-bit frames). The FIFO is empty, the overflow flag is clear and no frame is requested.
- R5: A configuration write with `wr_full_word` low is ignored. No entry is queued and the active word stays unchanged. When both strobes are high, the configuration strobe takes precedence.
- R6: When an applied configuration word has bit 18 (no-data start) set, it raises one frame request with `frm_nodata` high before any later entry is served. When bit 18 is clear, applying the word raises no frame request by itself.
- R7: A cycle with `cs_negated` high clears bit 18 of the active configuration.
- R8: Applying a configuration word while `eng_active` is high pulses `frm_abort` for one cycle. The exception is when bit 20 (continue) of the new word is set and `eng_boundary` is high.
- R9: `fifo_full` and `fifo_empty` reflect occupancy of DEPTH entries. A write to a full FIFO is dropped and sets the sticky `overflow` flag, which only reset clears.
- R10: `cfg_rd` returns the active configuration, not a word that is still queued.
- R11: A data entry leaves the FIFO only in a cycle where `frm_req` and `frm_accept` are both high. Until then, `frm_data` holds it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_cfg | input | 1 | Write strobe for the configuration address |
| wr_data | input | 1 | Write strobe for the data address |
| wr_full_word | input | 1 | High when the access is a full 32-bit write |
| wr_value | input | 32 | Write payload |
| frm_req | output | 1 | Frame request to the shift engine |
| frm_accept | input | 1 | Shift engine takes the request |
| frm_nodata | output | 1 | Request is a no-data frame started by a configuration word |
| frm_data | output | 32 | Data word of the request |
| frm_cfg | output | 32 | Configuration the frame must use |
| frm_abort | output | 1 | Ends the frame in progress |
| eng_active | input | 1 | Engine is inside a frame |
| eng_boundary | input | 1 | Engine is at a frame-size boundary |
| cs_negated | input | 1 | Chip select has negated |
| cfg_rd | output | 32 | Active configuration readback |
| fifo_full | output | 1 | FIFO holds DEPTH entries |
| fifo_empty | output | 1 | FIFO holds no entry |
| overflow | output | 1 | Sticky dropped-write flag |

## Verification
The bench builds the block with the default DEPTH of 8. At that depth, nine back-to-back data writes against a stalled engine are enough to reach the full flag, the dropped ninth word and the sticky overflow flag. Holding `frm_accept` low also strands a configuration word behind a data word, so readback and per-frame configuration can be told apart. The bench drives `eng_active` and `eng_boundary` directly, so each of the three abort cases for a new configuration word is reached on its own.

// File: rtl/spi_txq_pkg.sv
package spi_txq_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned NODATA_BIT = 18;
  localparam int unsigned CONT_BIT   = 20;
  localparam logic [WORD_W-1:0] CFG_RESET = 32'h0000_001F;

  typedef struct packed {
    logic              is_cfg;
    logic [WORD_W-1:0] payload;
  } txq_entry_t;

  // Drop the no-data start bit from a configuration word.
  function automatic logic [WORD_W-1:0] strip_nodata(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    r = w;
    r[NODATA_BIT] = 1'b0;
    return r;
  endfunction

  // A new word leaves the running stream alive only on a boundary with continue set.
  function automatic logic keeps_stream(input logic [WORD_W-1:0] w, input logic at_boundary);
    return w[CONT_BIT] && at_boundary;
  endfunction
endpackage

// File: rtl/txq_fifo.sv
module txq_fifo
  import spi_txq_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  txq_entry_t push_entry,
  input  logic       pop,
  output txq_entry_t head,
  output logic       full,
  output logic       empty
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  txq_entry_t    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign full    = (count == FULL_CNT);
  assign empty   = (count == '0);
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_entry;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  a_r9_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> full);
  a_r9_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);
  a_r1_pop_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/txq_cfg_ctl.sv
module txq_cfg_ctl
  import spi_txq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              head_valid,
  input  txq_entry_t        head,
  input  logic              frm_accept,
  input  logic              eng_active,
  input  logic              eng_boundary,
  input  logic              cs_negated,
  output logic [WORD_W-1:0] active,
  output logic              cfg_pop,
  output logic              data_pop,
  output logic              frm_req,
  output logic              frm_nodata,
  output logic              frm_abort
);
  logic              head_cfg, head_dat;
  logic              nodata_pend, nodata_done;
  logic [WORD_W-1:0] active_d;

  assign head_cfg    = head_valid && head.is_cfg;
  assign head_dat    = head_valid && !head.is_cfg;
  assign cfg_pop     = head_cfg && !nodata_pend;
  assign frm_req     = nodata_pend || head_dat;
  assign frm_nodata  = nodata_pend;
  assign data_pop    = head_dat && !nodata_pend && frm_accept;
  assign nodata_done = nodata_pend && frm_accept;
  assign frm_abort   = cfg_pop && eng_active && !keeps_stream(head.payload, eng_boundary);

  always_comb begin
    active_d = cfg_pop ? head.payload : active;
    if (cs_negated) active_d = strip_nodata(active_d);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active      <= CFG_RESET;
      nodata_pend <= 1'b0;
    end else begin
      active <= active_d;
      if (cfg_pop)          nodata_pend <= head.payload[NODATA_BIT];
      else if (nodata_done) nodata_pend <= 1'b0;
    end
  end

  a_r2_cfg_applied: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_pop && !cs_negated) |=> active == $past(head.payload));
  a_r3_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_pop && !cs_negated) |=> $stable(active));
  a_r7_cs_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cs_negated |=> !active[NODATA_BIT]);
  a_r6_nodata_first: assert property (@(posedge clk) disable iff (!rst_n)
    frm_nodata |-> (!data_pop && !cfg_pop));
  a_r8_abort_with_apply: assert property (@(posedge clk) disable iff (!rst_n)
    frm_abort |-> (cfg_pop && eng_active));
  a_r11_data_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    data_pop |-> (frm_accept && frm_req));
endmodule

// File: rtl/spi_txq_top.sv
module spi_txq_top
  import spi_txq_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_cfg,
  input  logic        wr_data,
  input  logic        wr_full_word,
  input  logic [31:0] wr_value,
  output logic        frm_req,
  input  logic        frm_accept,
  output logic        frm_nodata,
  output logic [31:0] frm_data,
  output logic [31:0] frm_cfg,
  output logic        frm_abort,
  input  logic        eng_active,
  input  logic        eng_boundary,
  input  logic        cs_negated,
  output logic [31:0] cfg_rd,
  output logic        fifo_full,
  output logic        fifo_empty,
  output logic        overflow
);
  logic              push_cfg, push_any, pop_any;
  logic              cfg_pop, data_pop;
  txq_entry_t        push_entry, head;
  logic [WORD_W-1:0] active;

  assign push_cfg   = wr_cfg && wr_full_word;
  assign push_any   = push_cfg || (wr_data && !wr_cfg);
  assign push_entry = '{is_cfg: push_cfg, payload: wr_value};
  assign pop_any    = cfg_pop || data_pop;

  txq_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (push_any),
    .push_entry (push_entry),
    .pop        (pop_any),
    .head       (head),
    .full       (fifo_full),
    .empty      (fifo_empty)
  );

  txq_cfg_ctl u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .head_valid   (!fifo_empty),
    .head         (head),
    .frm_accept   (frm_accept),
    .eng_active   (eng_active),
    .eng_boundary (eng_boundary),
    .cs_negated   (cs_negated),
    .active       (active),
    .cfg_pop      (cfg_pop),
    .data_pop     (data_pop),
    .frm_req      (frm_req),
    .frm_nodata   (frm_nodata),
    .frm_abort    (frm_abort)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                     overflow <= 1'b0;
    else if (push_any && fifo_full) overflow <= 1'b1;
  end

  assign frm_data = head.payload;
  assign frm_cfg  = active;
  assign cfg_rd   = active;

  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_full && fifo_empty));
endmodule

// File: tb/tb_spi_txq_top.sv
module tb_spi_txq_top;
  typedef struct packed {
    logic        nd;
    logic [31:0] d;
    logic [31:0] cfg;
  } frame_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_cfg = 1'b0, wr_data = 1'b0, wr_full_word = 1'b0;
  logic [31:0] wr_value = '0;
  logic        frm_req, frm_nodata, frm_abort;
  logic        frm_accept = 1'b1;
  logic [31:0] frm_data, frm_cfg, cfg_rd;
  logic        eng_active = 1'b0, eng_boundary = 1'b0, cs_negated = 1'b0;
  logic        fifo_full, fifo_empty, overflow;

  int     n_chk = 0, n_fail = 0, n_abort = 0;
  bit     done = 1'b0;
  frame_t expq[$];

  always #5 clk = ~clk;

  spi_txq_top #(.DEPTH(8)) dut (
    .clk(clk), .rst_n(rst_n), .wr_cfg(wr_cfg), .wr_data(wr_data),
    .wr_full_word(wr_full_word), .wr_value(wr_value), .frm_req(frm_req),
    .frm_accept(frm_accept), .frm_nodata(frm_nodata), .frm_data(frm_data),
    .frm_cfg(frm_cfg), .frm_abort(frm_abort), .eng_active(eng_active),
    .eng_boundary(eng_boundary), .cs_negated(cs_negated), .cfg_rd(cfg_rd),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .overflow(overflow)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // Writes start at posedge+2 and are captured at the next edge.
  task automatic wr(input bit is_cfg, input bit full, input logic [31:0] v);
    wr_cfg = is_cfg; wr_data = !is_cfg; wr_full_word = full; wr_value = v;
    @(posedge clk); #2;
    wr_cfg = 0; wr_data = 0; wr_full_word = 0;
  endtask

  task automatic put_data(input logic [31:0] v, input logic [31:0] cfg);
    expq.push_back('{nd: 1'b0, d: v, cfg: cfg});
    wr(0, 1, v);
  endtask

  // Monitor: scoreboard compare on every handshake.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && frm_abort) n_abort++;
      if (rst_n && frm_req && frm_accept) begin
        if (expq.size() == 0) begin
          chk(0, "R6 unexpected frame", frm_data, 32'h0);
        end else begin
          frame_t e;
          e = expq.pop_front();
          chk(frm_nodata == e.nd, "R6 nodata flag", {31'b0, frm_nodata}, {31'b0, e.nd});
          if (!e.nd) chk(frm_data == e.d, "R1 frame data order", frm_data, e.d);
          chk(frm_cfg == e.cfg, "R2 frame configuration", frm_cfg, e.cfg);
        end
      end
    end
  end

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    logic [31:0] c1, c2, cm, c3, c4, c5;
    c1 = 32'h0000_0007; c2 = 32'h0000_000F; cm = 32'h0004_000F;
    c3 = 32'h0000_0003; c4 = 32'h0010_0005; c5 = 32'h0010_0006;
    idle(3);
    rst_n = 1;
    idle(1);
    // R4 reset state
    chk(cfg_rd == 32'h1F, "R4 reset config", cfg_rd, 32'h1F);
    chk(fifo_empty && !fifo_full && !overflow && !frm_req, "R4 reset flags",
        {28'b0, fifo_empty, fifo_full, overflow, frm_req}, 32'h8);

    // R2 default config on plain data
    put_data(32'hA5A5_0001, 32'h1F);
    idle(3);

    // R2 config then data
    wr(1, 1, c1);
    put_data(32'hA5A5_0002, c1);
    idle(3);
    chk(cfg_rd == c1, "R2 applied config", cfg_rd, c1);

    // R5 narrow config write ignored
    wr(1, 0, 32'hDEAD_0003);
    idle(3);
    chk(cfg_rd == c1, "R5 narrow write ignored", cfg_rd, c1);
    chk(fifo_empty, "R5 nothing queued", {31'b0, fifo_empty}, 32'h1);
    put_data(32'hA5A5_0005, c1);
    idle(3);

    // R10 / R11 / R1: config stranded behind held data
    frm_accept = 0;
    put_data(32'hA5A5_0003, c1);
    wr(1, 1, c2);
    put_data(32'hA5A5_0004, c2);
    idle(3);
    chk(cfg_rd == c1, "R10 readback shows active", cfg_rd, c1);
    chk(frm_req && frm_data == 32'hA5A5_0003, "R11 data held until accept", frm_data, 32'hA5A5_0003);
    frm_accept = 1;
    idle(5);
    chk(cfg_rd == c2, "R2 queued config applied in order", cfg_rd, c2);

    // R6 no-data start, R7 chip-select clears the bit
    expq.push_back('{nd: 1'b1, d: 32'h0, cfg: cm});
    wr(1, 1, cm);
    idle(4);
    chk(cfg_rd == cm, "R6 no-data config active", cfg_rd, cm);
    chk(!frm_req, "R6 single no-data frame", {31'b0, frm_req}, 32'h0);
    cs_negated = 1;
    idle(1);
    cs_negated = 0;
    idle(1);
    chk(cfg_rd == 32'h0000_000F, "R7 chip select clears no-data bit", cfg_rd, 32'h0000_000F);
    chk(!frm_req, "R3 no frame from plain config", {31'b0, frm_req}, 32'h0);

    // R8 abort rules
    eng_active = 1; eng_boundary = 0;
    wr(1, 1, c3);
    idle(3);
    chk(n_abort == 1, "R8 abort without continue", n_abort, 1);
    eng_boundary = 1;
    wr(1, 1, c4);
    idle(3);
    chk(n_abort == 1, "R8 continue on boundary keeps stream", n_abort, 1);
    eng_boundary = 0;
    wr(1, 1, c5);
    idle(3);
    chk(n_abort == 2, "R8 continue off boundary aborts", n_abort, 2);
    eng_active = 0;
    chk(cfg_rd == c5, "R2 last config applied", cfg_rd, c5);

    // R9 overflow on a stalled engine
    frm_accept = 0;
    for (int i = 0; i < 9; i++) begin
      if (i < 8) put_data(32'hB000_0000 + i, c5);
      else wr(0, 1, 32'hB000_0000 + i);
    end
    idle(1);
    chk(fifo_full, "R9 full flag", {31'b0, fifo_full}, 32'h1);
    chk(overflow, "R9 overflow set", {31'b0, overflow}, 32'h1);
    frm_accept = 1;
    idle(12);
    chk(fifo_empty, "R9 drained", {31'b0, fifo_empty}, 32'h1);
    chk(overflow, "R9 overflow sticky", {31'b0, overflow}, 32'h1);
    chk(expq.size() == 0, "R1 all frames delivered", expq.size(), 0);

    done = 1;
    report();
  end
endmodule